// File: doc/BRIEF.md
# Instruction Fetch Mapper with Repeat Sequencer

This block owns the word-addressed program counter of a small processor core. From that counter it forms a byte fetch address and maps it through one of two mapping registers. The choice between the two registers depends on which half of the fetch space the address falls in. A mapping register either points the fetch at instruction memory or at one segment of a unified memory. A segment that is not populated raises a fault.

After each retired instruction word the counter moves forward by one, or loads a branch target. A zero-overhead repeat loop is also supported: once a repeat count has been written, retiring the word at the loop-end address sends the counter back to the loop-start address until the count runs out.

A small controller gates all of this. It starts stopped, and the go input sets it running. It stops on a fetch fault, on an exception reported by execution, or after one word when single-step is requested, and it records why it stopped. The states are IDLE (after reset), RUN and HALT. The transitions are IDLE to RUN on go, RUN to HALT on fault, exception or step trap, and HALT to RUN on go.

Top module: `fetch_repeat_unit`

## Requirements
- R1: After reset the counter is 0xFFC0 and both mapping registers hold 0x1000 (instruction memory, segment 0). The unit is stopped with cause 0, so the fetch address reads 0x3FF00 with the instruction-memory target set.
- R2: The byte fetch address is the counter shifted left by two. Byte-address bit 17 set selects mapping register 1 (config select 1); clear selects mapping register 0 (config select 0).
- R3: A selected mapping value with bit 12 set targets instruction memory with the full 18-bit byte address. With bit 12 clear it targets unified segment value[7:0], and the address is cut to its low 17 bits.
- R4: A unified fetch to a segment outside the populated set (default: 0, 1, 2, 127) raises the fault output. When this happens while running, the unit halts with cause 3 and ignores retire pulses.
- R5: While running, a retire pulse advances the counter by one. If redirect accompanies the pulse, the counter loads the target instead.
- R6: With repeat armed, a retire that leaves the counter at the loop-end value decrements the count. If the result is nonzero the counter reloads loop start; if it is zero, repeat disarms and the counter goes to end plus one.
- R7: Config select 2 writes loop start, select 3 writes loop end and select 4 writes the count. Writing a nonzero count arms repeat; writing zero disarms it.
- R8: An exception input while running halts with cause 1. While stopped, the counter does not change.
- R9: With single-step requested, the first retire without exception or fault halts with cause 2. An exception on that same retire reports cause 1 instead.
- R10: Go from IDLE or HALT enters RUN and clears the cause to 0. While running the cause reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start or resume execution |
| retire_i | input | 1 | One instruction word retired this cycle |
| redirect_i | input | 1 | Retired word changed the counter |
| target_i | input | PC_W | New counter value on redirect |
| exc_i | input | 1 | Execution raised an exception |
| step_i | input | 1 | Single-step request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Register select: 0 map0, 1 map1, 2 loop start, 3 loop end, 4 count |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| fetch_imem_o | output | 1 | Fetch targets instruction memory (else unified) |
| fetch_seg_o | output | SEG_W | Unified segment number |
| fetch_addr_o | output | PC_W+2 | Byte fetch address |
| fetch_fault_o | output | 1 | Fetch to unpopulated segment |
| run_o | output | 1 | Controller in RUN |
| stop_cause_o | output | 2 | 0 none, 1 exception, 2 step trap, 3 fetch fault |

## Verification
The bench uses the default parameters: a 16-bit counter, 8-bit segment numbers, a 17-bit unified window and a populated set of segments 0, 1, 2 and 127. Because the reset counter lies in the upper half, mapping register 1 is exercised from the first cycle. Redirecting to 0x8010 with a unified mapping shows bit 17 being removed. Segment 5 is outside the populated set, which makes the fault path reachable with a single configuration write.

// File: rtl/fru_pkg.sv
package fru_pkg;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_HALT = 2'd2} fsm_t;
    typedef enum logic [1:0] {
        CZ_NONE  = 2'd0,
        CZ_EXC   = 2'd1,
        CZ_TRAP  = 2'd2,
        CZ_FAULT = 2'd3
    } cause_t;
    localparam logic [2:0] CFG_MAP_LO    = 3'd0;
    localparam logic [2:0] CFG_RPT_START = 3'd2;
    localparam logic [2:0] CFG_RPT_END   = 3'd3;
    localparam logic [2:0] CFG_RPT_CNT   = 3'd4;
endpackage

// File: rtl/fru_map.sv
module fru_map
    import fru_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter int UNI_W    = 17,
    parameter int SEG_W    = 8,
    parameter logic RST_IMEM = 1'b1,
    parameter logic [SEG_W-1:0] RST_SEG = '0,
    parameter logic [(1<<SEG_W)-1:0] SEG_POP = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic               wr_imem,
    input  logic [SEG_W-1:0]   wr_seg,
    input  logic [PC_W-1:0]    pc,
    output logic               to_imem,
    output logic [SEG_W-1:0]   seg,
    output logic [PC_W+1:0]    addr,
    output logic               fault
);
    localparam int BA_W = PC_W + 2;
    localparam int HALF_BIT = UNI_W;

    logic [BA_W-1:0] byte_addr;
    logic            m_imem [2];
    logic [SEG_W-1:0] m_seg [2];

    for (genvar g = 0; g < 2; g++) begin : g_map
        logic             imem_q;
        logic [SEG_W-1:0] seg_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                imem_q <= RST_IMEM;
                seg_q  <= RST_SEG;
            end else if (cfg_we && cfg_sel == CFG_MAP_LO + 3'(g)) begin
                imem_q <= wr_imem;
                seg_q  <= wr_seg;
            end
        end
        assign m_imem[g] = imem_q;
        assign m_seg[g]  = seg_q;
    end

    always_comb begin
        byte_addr = {pc, 2'b00};
        to_imem   = byte_addr[HALF_BIT] ? m_imem[1] : m_imem[0];
        seg       = byte_addr[HALF_BIT] ? m_seg[1]  : m_seg[0];
        addr      = to_imem ? byte_addr
                            : {{(BA_W-UNI_W){1'b0}}, byte_addr[UNI_W-1:0]};
        fault     = !to_imem && !SEG_POP[seg];
    end
endmodule

// File: rtl/fru_seq.sv
module fru_seq
    import fru_pkg::*;
#(
    parameter int PC_W = 16,
    parameter int CNT_W = 16,
    parameter logic [PC_W-1:0] PC_RST = 16'hFFC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             redirect,
    input  logic [PC_W-1:0]  target,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [PC_W-1:0]  wr_pc,
    input  logic [CNT_W-1:0] wr_cnt,
    output logic [PC_W-1:0]  pc,
    output logic             rpt_on,
    output logic [PC_W-1:0]  rpt_start,
    output logic [PC_W-1:0]  rpt_end,
    output logic [CNT_W-1:0] rpt_cnt
);
    logic [PC_W-1:0]  base;
    logic             at_end;
    logic [CNT_W-1:0] cnt_dec;

    always_comb begin
        base    = redirect ? target : pc;
        at_end  = rpt_on && (base == rpt_end);
        cnt_dec = rpt_cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc        <= PC_RST;
            rpt_on    <= 1'b0;
            rpt_start <= '0;
            rpt_end   <= '0;
            rpt_cnt   <= '0;
        end else begin
            if (adv) begin
                if (at_end) begin
                    rpt_cnt <= cnt_dec;
                    if (cnt_dec == '0) begin
                        rpt_on <= 1'b0;
                        pc     <= base + PC_W'(1);
                    end else begin
                        pc <= rpt_start;
                    end
                end else if (redirect) begin
                    pc <= target;
                end else begin
                    pc <= pc + PC_W'(1);
                end
            end
            if (cfg_we) begin
                unique case (cfg_sel)
                    CFG_RPT_START: rpt_start <= wr_pc;
                    CFG_RPT_END:   rpt_end   <= wr_pc;
                    CFG_RPT_CNT: begin
                        rpt_cnt <= wr_cnt;
                        rpt_on  <= (wr_cnt != '0);
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fru_ctrl.sv
module fru_ctrl
    import fru_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       retire,
    input  logic       exc,
    input  logic       step,
    input  logic       fault,
    output logic       run,
    output logic       adv,
    output logic [1:0] cause
);
    fsm_t   state_q, state_nx;
    cause_t cause_q, cause_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= CZ_NONE;
        end else begin
            state_q <= state_nx;
            cause_q <= cause_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        cause_nx = cause_q;
        unique case (state_q)
            ST_IDLE, ST_HALT: begin
                if (go) begin
                    state_nx = ST_RUN;
                    cause_nx = CZ_NONE;
                end
            end
            ST_RUN: begin
                if (fault) begin
                    state_nx = ST_HALT;
                    cause_nx = CZ_FAULT;
                end else if (exc) begin
                    state_nx = ST_HALT;
                    cause_nx = CZ_EXC;
                end else if (retire && step) begin
                    state_nx = ST_HALT;
                    cause_nx = CZ_TRAP;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cause_nx = CZ_NONE;
            end
        endcase
    end

    always_comb begin
        run   = (state_q == ST_RUN);
        adv   = run && retire && !fault;
        cause = cause_q;
    end
endmodule

// File: rtl/fetch_repeat_unit.sv
module fetch_repeat_unit
    import fru_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 16,
    parameter int UNI_W  = 17,
    parameter int SEG_W  = 8,
    parameter int IMEM_BIT = 12,
    parameter logic [DATA_W-1:0] MAP_RST = 16'h1000,
    parameter logic [PC_W-1:0]   PC_RST  = 16'hFFC0,
    parameter logic [(1<<SEG_W)-1:0] SEG_POP =
        {128'h0, 128'h80000000_00000000_00000000_00000007}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              retire_i,
    input  logic              redirect_i,
    input  logic [PC_W-1:0]   target_i,
    input  logic              exc_i,
    input  logic              step_i,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_sel_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic              fetch_imem_o,
    output logic [SEG_W-1:0]  fetch_seg_o,
    output logic [PC_W+1:0]   fetch_addr_o,
    output logic              fetch_fault_o,
    output logic              run_o,
    output logic [1:0]        stop_cause_o
);
    localparam int CNT_W = DATA_W;

    logic             adv_w;
    logic [PC_W-1:0]  pc_w;
    logic             rpt_on_w;
    logic [PC_W-1:0]  rpt_start_w;
    logic [PC_W-1:0]  rpt_end_w;
    logic [CNT_W-1:0] rpt_cnt_w;

    fru_map #(
        .PC_W(PC_W), .UNI_W(UNI_W), .SEG_W(SEG_W),
        .RST_IMEM(MAP_RST[IMEM_BIT]), .RST_SEG(MAP_RST[SEG_W-1:0]),
        .SEG_POP(SEG_POP)
    ) u_map (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we_i), .cfg_sel(cfg_sel_i),
        .wr_imem(cfg_wdata_i[IMEM_BIT]), .wr_seg(cfg_wdata_i[SEG_W-1:0]),
        .pc(pc_w),
        .to_imem(fetch_imem_o), .seg(fetch_seg_o),
        .addr(fetch_addr_o), .fault(fetch_fault_o)
    );

    fru_seq #(.PC_W(PC_W), .CNT_W(CNT_W), .PC_RST(PC_RST)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .adv(adv_w), .redirect(redirect_i), .target(target_i),
        .cfg_we(cfg_we_i), .cfg_sel(cfg_sel_i),
        .wr_pc(cfg_wdata_i[PC_W-1:0]), .wr_cnt(cfg_wdata_i[CNT_W-1:0]),
        .pc(pc_w), .rpt_on(rpt_on_w), .rpt_start(rpt_start_w),
        .rpt_end(rpt_end_w), .rpt_cnt(rpt_cnt_w)
    );

    fru_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .go(go_i), .retire(retire_i), .exc(exc_i), .step(step_i),
        .fault(fetch_fault_o),
        .run(run_o), .adv(adv_w), .cause(stop_cause_o)
    );
endmodule

// File: rtl/fru_chk.sv
module fru_chk #(
    parameter int PC_W  = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_o,
    input logic             retire_i,
    input logic             redirect_i,
    input logic             exc_i,
    input logic             step_i,
    input logic             cfg_we_i,
    input logic             fetch_fault_o,
    input logic [1:0]       stop_cause_o,
    input logic [PC_W-1:0]  pc_w,
    input logic             rpt_on_w,
    input logic [PC_W-1:0]  rpt_start_w,
    input logic [PC_W-1:0]  rpt_end_w,
    input logic [CNT_W-1:0] rpt_cnt_w
);
    AST_FAULT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        run_o && fetch_fault_o |=> !run_o && stop_cause_o == 2'd3); // R4
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run_o && retire_i && !redirect_i && !fetch_fault_o && !rpt_on_w
        |=> pc_w == $past(pc_w) + PC_W'(1)); // R5
    AST_RPT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        run_o && retire_i && !redirect_i && !fetch_fault_o && !cfg_we_i && rpt_on_w
        && pc_w == rpt_end_w && rpt_cnt_w != CNT_W'(1)
        |=> pc_w == $past(rpt_start_w)); // R6
    AST_RPT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_o && retire_i && !redirect_i && !fetch_fault_o && !cfg_we_i && rpt_on_w
        && pc_w == rpt_end_w && rpt_cnt_w == CNT_W'(1)
        |=> !rpt_on_w); // R6
    AST_EXC_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        run_o && exc_i && !fetch_fault_o |=> !run_o && stop_cause_o == 2'd1); // R8
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |=> $stable(pc_w)); // R8
    AST_STEP_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        run_o && step_i && retire_i && !exc_i && !fetch_fault_o
        |=> !run_o && stop_cause_o == 2'd2); // R9
    AST_RUN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> stop_cause_o == 2'd0); // R10
endmodule

bind fetch_repeat_unit fru_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_o(run_o), .retire_i(retire_i),
    .redirect_i(redirect_i), .exc_i(exc_i), .step_i(step_i),
    .cfg_we_i(cfg_we_i), .fetch_fault_o(fetch_fault_o),
    .stop_cause_o(stop_cause_o), .pc_w(pc_w), .rpt_on_w(rpt_on_w),
    .rpt_start_w(rpt_start_w), .rpt_end_w(rpt_end_w), .rpt_cnt_w(rpt_cnt_w)
);

// File: tb/fetch_repeat_unit_tb.sv
`timescale 1ns/1ps
module fetch_repeat_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go_i = 1'b0, retire_i = 1'b0, redirect_i = 1'b0;
    logic [15:0] target_i = '0;
    logic        exc_i = 1'b0, step_i = 1'b0, cfg_we_i = 1'b0;
    logic [2:0]  cfg_sel_i = '0;
    logic [15:0] cfg_wdata_i = '0;
    logic        fetch_imem_o, fetch_fault_o, run_o;
    logic [7:0]  fetch_seg_o;
    logic [17:0] fetch_addr_o;
    logic [1:0]  stop_cause_o;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fetch_repeat_unit u_dut (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .retire_i(retire_i),
        .redirect_i(redirect_i), .target_i(target_i), .exc_i(exc_i),
        .step_i(step_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
        .cfg_wdata_i(cfg_wdata_i), .fetch_imem_o(fetch_imem_o),
        .fetch_seg_o(fetch_seg_o), .fetch_addr_o(fetch_addr_o),
        .fetch_fault_o(fetch_fault_o), .run_o(run_o),
        .stop_cause_o(stop_cause_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(logic [2:0] sel, logic [15:0] data);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic ret(logic redir, logic [15:0] tgt);
        retire_i = 1'b1; redirect_i = redir; target_i = tgt;
        @(negedge clk);
        retire_i = 1'b0; redirect_i = 1'b0;
    endtask

    task automatic go();
        go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "reset addr", 32'(fetch_addr_o), 32'h3FF00);
        chk("R1", "reset imem", 32'(fetch_imem_o), 32'd1);
        chk("R1", "reset run", 32'(run_o), 32'd0);
        chk("R1", "reset cause", 32'(stop_cause_o), 32'd0);
        chk("R1", "reset fault", 32'(fetch_fault_o), 32'd0);
    endtask

    task automatic t_advance();
        go();
        chk("R10", "running", 32'(run_o), 32'd1);
        ret(1'b0, 16'h0);
        chk("R5", "advance 1", 32'(fetch_addr_o), 32'h3FF04);
        ret(1'b0, 16'h0);
        chk("R5", "advance 2", 32'(fetch_addr_o), 32'h3FF08);
        ret(1'b1, 16'h0010);
        chk("R5", "redirect addr", 32'(fetch_addr_o), 32'h00040);
        chk("R2", "lower half map0 imem", 32'(fetch_imem_o), 32'd1);
    endtask

    task automatic t_map();
        cfg(3'd0, 16'h0001);
        chk("R3", "unified target", 32'(fetch_imem_o), 32'd0);
        chk("R3", "segment 1", 32'(fetch_seg_o), 32'd1);
        chk("R3", "unified addr", 32'(fetch_addr_o), 32'h00040);
        chk("R4", "populated no fault", 32'(fetch_fault_o), 32'd0);
        cfg(3'd1, 16'h0002);
        ret(1'b1, 16'h8010);
        chk("R2", "upper half uses map1 seg", 32'(fetch_seg_o), 32'd2);
        chk("R3", "truncated addr", 32'(fetch_addr_o), 32'h00040);
        cfg(3'd1, 16'h1000);
        chk("R3", "imem full addr", 32'(fetch_addr_o), 32'h20040);
        cfg(3'd0, 16'h1000);
    endtask

    task automatic t_repeat();
        ret(1'b1, 16'h0100);
        cfg(3'd2, 16'h0100);
        cfg(3'd3, 16'h0102);
        cfg(3'd4, 16'd2);
        ret(1'b0, 16'h0);
        ret(1'b0, 16'h0);
        chk("R6", "reach end", 32'(fetch_addr_o), 32'h408);
        ret(1'b0, 16'h0);
        chk("R6", "reload start", 32'(fetch_addr_o), 32'h400);
        ret(1'b0, 16'h0);
        ret(1'b0, 16'h0);
        ret(1'b0, 16'h0);
        chk("R6", "exit after count", 32'(fetch_addr_o), 32'h40C);
        ret(1'b1, 16'h0101);
        ret(1'b0, 16'h0);
        ret(1'b0, 16'h0);
        chk("R6", "disarmed no reload", 32'(fetch_addr_o), 32'h40C);
        cfg(3'd4, 16'd0);
        ret(1'b1, 16'h0101);
        ret(1'b0, 16'h0);
        ret(1'b0, 16'h0);
        chk("R7", "zero count no loop", 32'(fetch_addr_o), 32'h40C);
        cfg(3'd4, 16'd1);
        ret(1'b1, 16'h0102);
        chk("R7", "armed redirect onto end exits", 32'(fetch_addr_o), 32'h40C);
    endtask

    task automatic t_fault();
        cfg(3'd0, 16'h0005);
        chk("R4", "unpopulated fault", 32'(fetch_fault_o), 32'd1);
        @(negedge clk);
        chk("R4", "halt on fault", 32'(run_o), 32'd0);
        chk("R4", "fault cause", 32'(stop_cause_o), 32'd3);
        ret(1'b0, 16'h0);
        chk("R4", "retire ignored", 32'(fetch_addr_o), 32'h40C);
        cfg(3'd0, 16'h1000);
    endtask

    task automatic t_exc();
        go();
        chk("R10", "cause cleared", 32'(stop_cause_o), 32'd0);
        exc_i = 1'b1;
        @(negedge clk);
        exc_i = 1'b0;
        chk("R8", "halt on exc", 32'(run_o), 32'd0);
        chk("R8", "exc cause", 32'(stop_cause_o), 32'd1);
        ret(1'b0, 16'h0);
        chk("R8", "pc held", 32'(fetch_addr_o), 32'h40C);
    endtask

    task automatic t_step();
        go();
        step_i = 1'b1;
        ret(1'b0, 16'h0);
        chk("R9", "step advance", 32'(fetch_addr_o), 32'h410);
        chk("R9", "step halt", 32'(run_o), 32'd0);
        chk("R9", "trap cause", 32'(stop_cause_o), 32'd2);
        go();
        exc_i = 1'b1;
        ret(1'b0, 16'h0);
        exc_i = 1'b0;
        chk("R9", "exc beats trap", 32'(stop_cause_o), 32'd1);
        step_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_advance();
        t_map();
        t_repeat();
        t_fault();
        t_exc();
        t_step();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule